// File: doc/BRIEF.md
# Per-Rank Activation Window Limiter

This block tracks the row-activate commands that a memory controller sends to each rank of a DRAM channel. It keeps every rank within a configurable budget: at most `ACT_LIMIT` activates may fall inside any rolling window of `WINDOW` cycles. The scheduler reports each activate with a strobe, the target rank and the activate's timestamp. For every rank the block returns the earliest cycle at which a further activate may be issued. That bound covers every bank of the rank. The block also returns a combinational "go" bit that compares the bound against the free-running cycle counter.

Each rank keeps its own short history of recent activate times. Activity on one rank never delays another rank. The block also raises a one-cycle warning when an activate arrives although the window was already full. It raises a one-cycle error when the strobe names a rank that does not exist. The activate strobe is accepted in every cycle and is never back-pressured, so it has no ready signal. Setting `ACT_LIMIT` to zero disables tracking.

Top module: `act_window_limiter`

## Requirements
- R1: During and directly after reset every rank's allowed time is 0, every `act_go` bit is 1 while `now` is 0, and `window_viol` and `rank_err` are 0.
- R2: On an accepted activate at time T to rank r, the history keeps the ACT_LIMIT newest times, T included. Let O be the oldest of them. If O is nonzero and T−O (mod 2^32) is below WINDOW, then from the next cycle `allow_at[32r+31:32r]` equals O+WINDOW.
- R3: In any other case the allowed time of rank r keeps its previous value.
- R4: History entries start at 0, and an entry equal to 0 counts as empty: it takes part in neither the gating check nor the warning check, even when an activate was stamped at time 0.
- R5: `window_viol` is 1 for exactly the cycle after an activate whose rank already held a nonzero ACT_LIMIT-th most recent time less than WINDOW before T. The activate is still recorded.
- R6: An activate to one rank leaves the allowed times of all other ranks unchanged.
- R7: A strobe whose `act_rank` is NUM_RANKS or above changes no state, and `rank_err` is 1 in the following cycle.
- R8: `act_go[r]` is 1 exactly when `now` minus rank r's allowed time, taken mod 2^32, is non-negative as a signed 32-bit value. It responds in the same cycle.
- R9: With ACT_LIMIT = 0 every allowed time stays 0 and `window_viol` stays 0.
- R10: All time differences wrap modulo 2^32, so a window that spans the counter roll-over gates correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_valid | input | 1 | An activate was issued this cycle |
| act_rank | input | RANK_W | Target rank of the activate |
| act_time | input | 32 | Timestamp of the activate |
| now | input | 32 | Free-running cycle counter |
| allow_at | output | 32*NUM_RANKS | Earliest next-activate time per rank; rank r in bits [32r+31:32r] |
| act_go | output | NUM_RANKS | Rank may activate at `now` |
| window_viol | output | 1 | Warning: an activate arrived while the window was already full |
| rank_err | output | 1 | The previous strobe named a nonexistent rank |

## Verification
Two functions act on one activate in the same cycle: the warning check and the gating update. The warning check reads the oldest entry before the shift. The gating update reads the oldest entry after it. The bench issues ACT_LIMIT+1 activates close together on one rank, so that both checks fire on the same edge with different oldest entries. It also spaces activates so that only the gating update fires. Every cycle, a queue-based model in the bench predicts the warning bit and all ranks' allowed times independently of the RTL, and the bench compares them with the design.

// File: rtl/alw_pkg.sv
package alw_pkg;
  localparam int STAMP_W = 32;
  typedef logic [STAMP_W-1:0] stamp_t;

  // wrap-around distance from b forward to a
  function automatic stamp_t stamp_gap(input stamp_t a, input stamp_t b);
    return a - b;
  endfunction

  // true when a is at or after b, judged on the signed modular distance
  function automatic logic stamp_reached(input stamp_t a, input stamp_t b);
    stamp_t d;
    d = a - b;
    return ~d[STAMP_W-1];
  endfunction
endpackage

// File: rtl/act_rank_decode.sv
module act_rank_decode #(
  parameter int NUM_RANKS = 3,
  parameter int RANK_W    = 2
) (
  input  logic              act_valid,
  input  logic [RANK_W-1:0] act_rank,
  output logic [NUM_RANKS-1:0] hit,
  output logic              bad
);
  genvar r;
  generate
    for (r = 0; r < NUM_RANKS; r++) begin : g_hit
      assign hit[r] = act_valid && (act_rank == RANK_W'(r));
    end
  endgenerate

  // indices past the last rank are rejected (R7)
  assign bad = act_valid && (32'(act_rank) >= 32'(NUM_RANKS));
endmodule

// File: rtl/act_rank_history.sv
module act_rank_history
  import alw_pkg::*;
#(
  parameter int ACT_LIMIT = 4,
  parameter int WINDOW    = 40
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hit,
  input  stamp_t ts,
  output stamp_t allow_at,
  output logic   viol
);
  localparam stamp_t WIN = stamp_t'(WINDOW);

  generate
    if (ACT_LIMIT == 0) begin : g_off
      // tracking disabled (R9)
      assign allow_at = '0;
      assign viol     = 1'b0;
    end else begin : g_on
      stamp_t hist [ACT_LIMIT];
      stamp_t oldest_pre;
      stamp_t oldest_post;
      logic   viol_d;
      logic   gate_d;
      stamp_t allow_q;
      logic   viol_q;

      if (ACT_LIMIT == 1) begin : g_one
        assign oldest_post = ts;
      end else begin : g_many
        assign oldest_post = hist[ACT_LIMIT-2];
      end
      assign oldest_pre = hist[ACT_LIMIT-1];

      // zero entries are empty (R4); differences wrap (R10)
      assign viol_d = hit && (oldest_pre != '0) && (stamp_gap(ts, oldest_pre) < WIN);
      assign gate_d = hit && (oldest_post != '0) && (stamp_gap(ts, oldest_post) < WIN);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < ACT_LIMIT; i++) hist[i] <= '0;
          allow_q <= '0;
          viol_q  <= 1'b0;
        end else begin
          viol_q <= viol_d;
          if (hit) begin
            hist[0] <= ts;
            for (int i = 1; i < ACT_LIMIT; i++) hist[i] <= hist[i-1];
          end
          if (gate_d) allow_q <= oldest_post + WIN;
        end
      end

      assign allow_at = allow_q;
      assign viol     = viol_q;

      assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(allow_q));

      assert_gate_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(allow_q) |-> ($past(hit) && ((allow_q - $past(ts)) != '0)
                               && ((allow_q - $past(ts)) <= WIN)));
    end
  endgenerate
endmodule

// File: rtl/act_ready_cmp.sv
module act_ready_cmp
  import alw_pkg::*;
#(
  parameter int NUM_RANKS = 3
) (
  input  stamp_t                       now,
  input  logic [NUM_RANKS*STAMP_W-1:0] allow_bus,
  output logic [NUM_RANKS-1:0]         go
);
  genvar r;
  generate
    for (r = 0; r < NUM_RANKS; r++) begin : g_cmp
      // signed modular comparison (R8)
      assign go[r] = stamp_reached(now, allow_bus[r*STAMP_W +: STAMP_W]);
    end
  endgenerate
endmodule

// File: rtl/act_window_limiter.sv
module act_window_limiter
  import alw_pkg::*;
#(
  parameter int NUM_RANKS = 3,
  parameter int ACT_LIMIT = 4,
  parameter int WINDOW    = 40,
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS + 1) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         act_valid,
  input  logic [RANK_W-1:0]            act_rank,
  input  logic [STAMP_W-1:0]           act_time,
  input  logic [STAMP_W-1:0]           now,
  output logic [NUM_RANKS*STAMP_W-1:0] allow_at,
  output logic [NUM_RANKS-1:0]         act_go,
  output logic                         window_viol,
  output logic                         rank_err
);
  logic [NUM_RANKS-1:0] hit;
  logic [NUM_RANKS-1:0] viol_r;
  logic                 bad;
  logic                 err_q;

  act_rank_decode #(.NUM_RANKS(NUM_RANKS), .RANK_W(RANK_W)) u_dec (
    .act_valid(act_valid), .act_rank(act_rank), .hit(hit), .bad(bad)
  );

  genvar r;
  generate
    for (r = 0; r < NUM_RANKS; r++) begin : g_rank
      act_rank_history #(.ACT_LIMIT(ACT_LIMIT), .WINDOW(WINDOW)) u_hist (
        .clk(clk), .rst_n(rst_n), .hit(hit[r]), .ts(act_time),
        .allow_at(allow_at[r*STAMP_W +: STAMP_W]), .viol(viol_r[r])
      );
    end
  endgenerate

  act_ready_cmp #(.NUM_RANKS(NUM_RANKS)) u_cmp (
    .now(now), .allow_bus(allow_at), .go(act_go)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= bad;
  end

  assign rank_err    = err_q;
  assign window_viol = |viol_r;

  // previous allowed times, kept only for the checks below
  logic [NUM_RANKS*STAMP_W-1:0] allow_prev;
  logic [NUM_RANKS-1:0]         moved;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) allow_prev <= '0;
    else        allow_prev <= allow_at;
  end
  always_comb begin
    for (int i = 0; i < NUM_RANKS; i++)
      moved[i] = allow_at[i*STAMP_W +: STAMP_W] != allow_prev[i*STAMP_W +: STAMP_W];
  end

  assert_one_rank_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(moved) <= 1);

  assert_err_no_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rank_err |-> (moved == '0));

  assert_viol_needs_act_R5: assert property (@(posedge clk) disable iff (!rst_n)
    window_viol |-> $past(act_valid));
endmodule

// File: tb/sim_act_window_limiter.sv
`timescale 1ns/1ps
module sim_act_window_limiter;
  localparam int NR = 3;
  localparam int XL = 4;
  localparam int WN = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        act_valid = 1'b0;
  logic [1:0]  act_rank = '0;
  logic [31:0] act_time = '0;
  logic [31:0] now = '0;
  logic [NR*32-1:0] allow0, allow1;
  logic [NR-1:0]    go0, go1;
  logic viol0, viol1, err0, err1;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  act_window_limiter #(.NUM_RANKS(NR), .ACT_LIMIT(XL), .WINDOW(WN)) u0 (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_rank(act_rank),
    .act_time(act_time), .now(now), .allow_at(allow0), .act_go(go0),
    .window_viol(viol0), .rank_err(err0));

  act_window_limiter #(.NUM_RANKS(NR), .ACT_LIMIT(0), .WINDOW(WN)) u1 (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_rank(act_rank),
    .act_time(act_time), .now(now), .allow_at(allow1), .act_go(go1),
    .window_viol(viol1), .rank_err(err1));

  // behavioural model
  logic [31:0] mh [NR][$];
  logic [31:0] m_allow [NR];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic go_of(input logic [31:0] t, input logic [31:0] a);
    logic [31:0] d;
    d = t - a;
    return ~d[31];
  endfunction

  task automatic step(input logic v, input logic [1:0] rk, input logic [31:0] ts,
                      input logic [31:0] tn, input string tag);
    logic ev, ee;
    logic [31:0] o;
    int rr;
    act_valid = v; act_rank = rk; act_time = ts; now = tn;
    #1;
    for (int r = 0; r < NR; r++) begin
      chk("R8 go", 32'(go0[r]), 32'(go_of(tn, m_allow[r])));
      chk("R9 go disabled", 32'(go1[r]), 32'(go_of(tn, 32'd0)));
    end
    ev = 1'b0; rr = -1;
    ee = v && (int'(rk) >= NR);
    if (v && !ee) begin
      rr = int'(rk);
      o = mh[rr][$];
      ev = (o != 0) && ((ts - o) < WN);
      void'(mh[rr].pop_back());
      mh[rr].push_front(ts);
      o = mh[rr][$];
      if ((o != 0) && ((ts - o) < WN)) m_allow[rr] = o + WN;
    end
    @(negedge clk);
    for (int r = 0; r < NR; r++) begin
      if (r == rr) chk({tag, " allow active rank R2 R3"}, allow0[r*32 +: 32], m_allow[r]);
      else         chk("R6 allow other rank", allow0[r*32 +: 32], m_allow[r]);
      chk("R9 allow disabled", allow1[r*32 +: 32], 32'd0);
    end
    chk("R5 viol", 32'(viol0), 32'(ev));
    chk("R9 viol disabled", 32'(viol1), 32'd0);
    chk("R7 rank_err", 32'(err0), 32'(ee));
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] tnow;
    for (int r = 0; r < NR; r++) begin
      m_allow[r] = '0;
      for (int i = 0; i < XL; i++) mh[r].push_back(32'd0);
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int r = 0; r < NR; r++) begin
      chk("R1 reset allow", allow0[r*32 +: 32], 32'd0);
      chk("R1 reset go", 32'(go0[r]), 32'd1);
    end
    chk("R1 reset viol", 32'(viol0), 32'd0);
    chk("R1 reset err", 32'(err0), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 filling the window on rank 0, then one more to also warn (R5)
    step(1, 0, 10, 10, "R2");
    step(1, 0, 12, 12, "R2");
    step(1, 0, 14, 14, "R2");
    step(1, 0, 16, 16, "R2");
    step(0, 0, 0, 30, "R8");
    step(1, 0, 20, 20, "R5");
    step(0, 0, 0, 52, "R8");
    // R3 widely spaced activates on rank 1 never gate
    for (int k = 1; k <= 6; k++) step(1, 1, 32'(100 + 50 * k), 32'(100 + 50 * k), "R3");
    // R7 nonexistent rank
    step(1, 3, 400, 400, "R7");
    step(0, 0, 0, 401, "R7");
    // R4 activate stamped at zero stays an empty entry
    step(1, 2, 0, 402, "R4");
    step(1, 2, 5, 403, "R4");
    step(1, 2, 6, 404, "R4");
    step(1, 2, 7, 405, "R4");
    step(1, 2, 8, 406, "R4");
    // R10 wrap-around on rank 2
    step(1, 2, 32'hFFFF_FFF0, 32'hFFFF_FFF0, "R10");
    step(1, 2, 32'hFFFF_FFF8, 32'hFFFF_FFF8, "R10");
    step(1, 2, 32'd2, 32'd2, "R10");
    step(1, 2, 32'd8, 32'd8, "R10");
    step(0, 0, 0, 32'd10, "R10");
    step(0, 0, 0, 32'd30, "R10");
    // mixed traffic
    tnow = 32'd1000;
    for (int k = 0; k < 3000; k++) begin
      tnow = tnow + 32'($urandom_range(1, 6));
      step(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), tnow, tnow, "R2");
    end
    summary();
    $finish;
  end
endmodule